// File: doc/BRIEF.md
# Multi-Bus I2C Command Processor

This block is the byte-level front end of an I2C master that can serve up to sixteen separate I2C buses from one host register window. The host loads an 8-bit argument into the data register, then writes a command code into the command register. The block carries out that command and reports the result in the command register: one bit says the command has finished, and three more bits report a missing acknowledge, a lost arbitration or an error. The host then reads this register until the finish bit is set. A control/status register enables the core, selects the bus and shows whether the selected bus is busy and whether this master holds it. A read-only monitor register shows the current byte-level state.

The block does not drive the bus wires. For each bus action it sends one request (start, repeated start, byte write, byte read, stop) to a separate bit sequencer, and it waits for that sequencer's completion pulse. The completion pulse carries the NAK, arbitration-lost and received-byte results.

Register offsets on `host_addr`: 0 control/status, 1 data, 2 command, 3 monitor. Reads are combinational. Writes take effect at the clock edge where `host_wr` is high.

Top module: `mbus_cmd_proc`

## Requirements
- R1: After reset the control/status register reads 0x00, the data register reads 0x00, the command register reads 0x80 (finished, no error bits) and the monitor reads 0x00.
- R2: The control/status register holds the following fields:
  - bit 7: core enable, read back as written.
  - bit 6: interrupt enable, read back as written.
  - bit 5: live busy input of the selected bus.
  - bit 4: this master holds the selected bus.
  - bits 3:0: selected bus number.
- R3: While the core is disabled, any command write finishes at once with the response finished+error. Clearing the enable bit also drops the captured state.
- R4: Set-Bus (code 6) with a data value below NBUS selects that bus and finishes with done. With a value of NBUS or more it finishes with finished+error and leaves the selection unchanged.
- R5: Command register layout:
  - Bits 3:0 show the last accepted code. Codes: 0 Wait, 1 Write, 2 Read-ACK, 3 Read-NAK, 4 Start, 5 Stop, 6 Set-Bus.
  - Response bits: bit 7 finished, bit 6 NAK, bit 5 arbitration lost, bit 4 error.
  - An accepted command that needs the bus clears the finished bit until it ends.
  - Codes 7 to 15 finish at once with finished+error.
- R6: Start while the bus is not held:
  - If the selected bus is free, one request with operation 1 (start) goes out to the selected bus.
  - If the selected bus is busy, the monitor shows state 2 and no request goes out until the busy input drops.
  - A clean completion sets the captured state and finishes with done.
- R7: Start while the bus is held sends operation 2 (repeated start) and finishes with done.
- R8: Write while the bus is held sends operation 3 with the data register as the byte. A NAK from the sequencer finishes with finished+NAK (0xC1) and keeps the bus held. Write while the bus is not held finishes at once with finished+error.
- R9: Read-ACK and Read-NAK send operation 4, with the acknowledge bit 1 and 0 respectively. On completion the data register holds the received byte, and the command finishes with done.
- R10: Arbitration lost reported for any request finishes with finished+arbitration-lost and clears the captured state.
- R11: Stop while the bus is held sends operation 5 and clears the captured state. Stop while the bus is not held finishes at once with done and sends no request.
- R12: Wait with data value d sets the finished bit exactly d*TICK_CYC+1 clock edges after the command write edge.
- R13: Command and data writes made while a command is in progress are ignored.
- R14: Monitor register:
  - Bits 7:4 show the byte-level state: 0 idle, 1 bus held, 2 start pending, 3 start, 4 stop, 5 byte write, 6 byte read, 7 waiting.
  - Bits 2:0 show the operation code of the request in flight, or 0 when none is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register offset |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Register read data for host_addr |
| bus_busy | input | NBUS | Per-bus busy indication |
| seq_req | output | 1 | One-cycle request pulse to the bit sequencer |
| seq_op | output | 3 | Requested operation (1 start, 2 repeated start, 3 write, 4 read, 5 stop) |
| seq_bus | output | 4 | Target bus number |
| seq_wbyte | output | 8 | Byte to send for a write |
| seq_ack_bit | output | 1 | 1 = acknowledge the byte being read |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_nak | input | 1 | Write was not acknowledged (with seq_done) |
| seq_arb_lost | input | 1 | Arbitration lost (with seq_done) |
| seq_rbyte | input | 8 | Received byte (with seq_done) |

## Verification
The following results become visible at the first falling edge after the command write edge:
- the immediate finished+error responses;
- the Set-Bus responses;
- Stop with the bus not held.

A request pulse appears one edge after the command write, and the response is set on the edge that samples the sequencer's completion pulse. A Wait finishes at d*TICK_CYC+1 edges after the write, and the bench counts falling edges from the write to the finished bit and compares the count with that formula. All inputs are driven and all outputs sampled at falling edges, so each check reads a value that has settled after the rising edge.

// File: rtl/mbus_pkg.sv
// Package: shared codes and encodings of the multi-bus command processor.
// Assumes: the host and the bit sequencer agree on these codes.
package mbus_pkg;

    // Register offsets
    localparam logic [1:0] RA_CSR  = 2'd0;
    localparam logic [1:0] RA_DATA = 2'd1;
    localparam logic [1:0] RA_CMD  = 2'd2;
    localparam logic [1:0] RA_MON  = 2'd3;

    // Command codes
    localparam logic [3:0] CMD_WAIT   = 4'd0;
    localparam logic [3:0] CMD_WRITE  = 4'd1;
    localparam logic [3:0] CMD_RD_ACK = 4'd2;
    localparam logic [3:0] CMD_RD_NAK = 4'd3;
    localparam logic [3:0] CMD_START  = 4'd4;
    localparam logic [3:0] CMD_STOP   = 4'd5;
    localparam logic [3:0] CMD_SETBUS = 4'd6;

    // Response nibble bits (command register bits 7:4)
    localparam logic [3:0] RSP_COMP = 4'b1000;
    localparam logic [3:0] RSP_NAK  = 4'b0100;
    localparam logic [3:0] RSP_ARB  = 4'b0010;
    localparam logic [3:0] RSP_ERR  = 4'b0001;

    // Byte-level states; the value is what the monitor reports
    typedef enum logic [3:0] {
        BS_IDLE  = 4'd0,
        BS_PEND  = 4'd2,
        BS_START = 4'd3,
        BS_STOP  = 4'd4,
        BS_WRITE = 4'd5,
        BS_READ  = 4'd6,
        BS_WAIT  = 4'd7
    } bstate_e;

    // Bit-sequencer operations
    typedef enum logic [2:0] {
        SQ_NONE   = 3'd0,
        SQ_START  = 3'd1,
        SQ_RSTART = 3'd2,
        SQ_WRITE  = 3'd3,
        SQ_READ   = 3'd4,
        SQ_STOP   = 3'd5
    } sq_op_e;

endpackage

// File: rtl/mbus_wait_timer.sv
// Module: mbus_wait_timer
// Counts a loaded 8-bit value down to zero, one step per TICK_CYC clocks.
// Assumes: load is a single-cycle strobe; zero is high whenever the count is 0.
module mbus_wait_timer #(
    parameter int TICK_CYC = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] count_in,
    output logic       zero
);
    localparam int DIV_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(TICK_CYC - 1);

    logic [7:0]       cnt_q;
    logic [DIV_W-1:0] div_q;

    // Load on strobe, otherwise step the prescaler and count while non-zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= '0;
        end else if (load) begin
            cnt_q <= count_in;
            div_q <= DIV_TOP;
        end else if (cnt_q != 8'd0) begin
            if (div_q == '0) begin
                cnt_q <= cnt_q - 8'd1;
                div_q <= DIV_TOP;
            end else begin
                div_q <= div_q - 1'b1;
            end
        end
    end

    assign zero = (cnt_q == 8'd0);

    // R12: without a load the count never grows
    cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != 8'd0) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/mbus_host_regs.sv
// Module: mbus_host_regs
// Host-side registers: enable bits, data register, and the read multiplexer.
// Assumes: reads are combinational; data writes are blocked while busy.
module mbus_host_regs
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       busy,
    input  logic       rd_load,
    input  logic [7:0] rd_byte,
    input  logic [3:0] bus_sel,
    input  logic       sel_busy,
    input  logic       captured,
    input  logic [3:0] rsp,
    input  logic [3:0] cmd_last,
    input  logic [7:0] mon,
    output logic       enable,
    output logic [7:0] data_q,
    output logic       cmd_wr
);
    logic irq_en_q;

    // Control bits: core enable and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            irq_en_q <= 1'b0;
        end else if (host_wr && host_addr == RA_CSR) begin
            enable   <= host_wdata[7];
            irq_en_q <= host_wdata[6];
        end
    end

    // Data register: host write when idle, received byte on read completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (rd_load)
            data_q <= rd_byte;
        else if (host_wr && host_addr == RA_DATA && !busy)
            data_q <= host_wdata;
    end

    assign cmd_wr = host_wr && (host_addr == RA_CMD);

    // Read multiplexer
    always_comb begin
        unique case (host_addr)
            RA_CSR:  host_rdata = {enable, irq_en_q, sel_busy, captured, bus_sel};
            RA_DATA: host_rdata = data_q;
            RA_CMD:  host_rdata = {rsp, cmd_last};
            default: host_rdata = mon;
        endcase
    end

    // R13: a data write while busy leaves the data register alone
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == RA_DATA && busy && !rd_load) |=> $stable(data_q));

endmodule

// File: rtl/mbus_byte_fsm.sv
// Module: mbus_byte_fsm
// Byte-level command engine: accepts one command at a time, issues bit-sequencer
// requests, tracks bus ownership and builds the response nibble.
// Assumes: the sequencer answers every request with exactly one seq_done pulse.
module mbus_byte_fsm
    import mbus_pkg::*;
#(
    parameter int NBUS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            cmd_wr,
    input  logic [3:0]      cmd_code,
    input  logic [7:0]      data_q,
    input  logic [NBUS-1:0] bus_busy,
    input  logic            timer_zero,
    input  logic            seq_done,
    input  logic            seq_nak,
    input  logic            seq_arb_lost,
    output logic            seq_req,
    output logic [2:0]      seq_op,
    output logic [7:0]      seq_wbyte,
    output logic            seq_ack_bit,
    output logic [3:0]      bus_sel,
    output logic            sel_busy,
    output logic            captured,
    output logic            busy,
    output logic [3:0]      rsp,
    output logic [3:0]      cmd_last,
    output logic [7:0]      mon,
    output logic            timer_load,
    output logic            rd_load
);
    bstate_e     state_q;
    sq_op_e      op_q;
    logic [15:0] busy_pad;

    assign busy_pad = 16'(bus_busy);
    assign sel_busy = busy_pad[bus_sel];
    assign busy     = (state_q != BS_IDLE);
    assign seq_op   = op_q;

    assign timer_load = cmd_wr && enable && !busy && (cmd_code == CMD_WAIT);
    assign rd_load    = enable && (state_q == BS_READ) && seq_done && !seq_arb_lost;

    // Monitor: state nibble (idle splits by ownership) and in-flight operation
    always_comb begin
        mon[7:4] = (state_q == BS_IDLE) ? {3'b000, captured} : state_q;
        mon[3]   = 1'b0;
        mon[2:0] = op_q;
    end

    // Command acceptance, request issue and completion handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= BS_IDLE;
            op_q        <= SQ_NONE;
            seq_req     <= 1'b0;
            seq_wbyte   <= '0;
            seq_ack_bit <= 1'b0;
            bus_sel     <= '0;
            captured    <= 1'b0;
            rsp         <= RSP_COMP;
            cmd_last    <= '0;
        end else begin
            seq_req <= 1'b0;
            if (!enable) begin
                state_q  <= BS_IDLE;
                op_q     <= SQ_NONE;
                captured <= 1'b0;
                if (busy) begin
                    rsp <= RSP_COMP | RSP_ERR;
                end else if (cmd_wr) begin
                    cmd_last <= cmd_code;
                    rsp      <= RSP_COMP | RSP_ERR;
                end
            end else if (!busy) begin
                if (cmd_wr) begin
                    cmd_last <= cmd_code;
                    rsp      <= 4'b0000;
                    case (cmd_code)
                        CMD_WAIT: state_q <= BS_WAIT;
                        CMD_WRITE: begin
                            if (captured) begin
                                state_q   <= BS_WRITE;
                                op_q      <= SQ_WRITE;
                                seq_req   <= 1'b1;
                                seq_wbyte <= data_q;
                            end else begin
                                rsp <= RSP_COMP | RSP_ERR;
                            end
                        end
                        CMD_RD_ACK, CMD_RD_NAK: begin
                            if (captured) begin
                                state_q     <= BS_READ;
                                op_q        <= SQ_READ;
                                seq_req     <= 1'b1;
                                seq_ack_bit <= (cmd_code == CMD_RD_ACK);
                            end else begin
                                rsp <= RSP_COMP | RSP_ERR;
                            end
                        end
                        CMD_START: begin
                            if (captured) begin
                                state_q <= BS_START;
                                op_q    <= SQ_RSTART;
                                seq_req <= 1'b1;
                            end else if (sel_busy) begin
                                state_q <= BS_PEND;
                            end else begin
                                state_q <= BS_START;
                                op_q    <= SQ_START;
                                seq_req <= 1'b1;
                            end
                        end
                        CMD_STOP: begin
                            if (captured) begin
                                state_q <= BS_STOP;
                                op_q    <= SQ_STOP;
                                seq_req <= 1'b1;
                            end else begin
                                rsp <= RSP_COMP;
                            end
                        end
                        CMD_SETBUS: begin
                            if (int'(data_q) >= NBUS) begin
                                rsp <= RSP_COMP | RSP_ERR;
                            end else begin
                                bus_sel <= data_q[3:0];
                                rsp     <= RSP_COMP;
                            end
                        end
                        default: rsp <= RSP_COMP | RSP_ERR;
                    endcase
                end
            end else begin
                case (state_q)
                    BS_PEND: begin
                        if (!sel_busy) begin
                            state_q <= BS_START;
                            op_q    <= SQ_START;
                            seq_req <= 1'b1;
                        end
                    end
                    BS_WAIT: begin
                        if (timer_zero) begin
                            state_q <= BS_IDLE;
                            rsp     <= RSP_COMP;
                        end
                    end
                    default: begin
                        if (seq_done) begin
                            state_q <= BS_IDLE;
                            op_q    <= SQ_NONE;
                            if (seq_arb_lost) begin
                                captured <= 1'b0;
                                rsp      <= RSP_COMP | RSP_ARB;
                            end else begin
                                case (state_q)
                                    BS_START: begin
                                        captured <= 1'b1;
                                        rsp      <= RSP_COMP;
                                    end
                                    BS_STOP: begin
                                        captured <= 1'b0;
                                        rsp      <= RSP_COMP;
                                    end
                                    BS_WRITE: rsp <= seq_nak ? (RSP_COMP | RSP_NAK) : RSP_COMP;
                                    default:  rsp <= RSP_COMP;
                                endcase
                            end
                        end
                    end
                endcase
            end
        end
    end

    // R6: requests are single-cycle pulses
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req |=> !seq_req);

    // R13: command writes while busy do not change the recorded code
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> $stable(cmd_last));

    // R5: the finished bit is only seen in a resting state
    comp_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp[3] |-> (state_q == BS_IDLE));

    // R6: ownership is gained only on a sequencer completion
    capture_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(captured) |-> $past(seq_done));

    // R3: a disabled core holds no bus
    disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !captured);

endmodule

// File: rtl/mbus_cmd_proc.sv
// Module: mbus_cmd_proc (top)
// Multi-bus I2C command processor: host register window over a byte-level
// engine that drives an external bit sequencer.
// Assumes: NBUS <= 16; the bit sequencer produces the bus waveforms.
module mbus_cmd_proc #(
    parameter int NBUS     = 16,
    parameter int TICK_CYC = 50
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr,
    input  logic [1:0]      host_addr,
    input  logic [7:0]      host_wdata,
    output logic [7:0]      host_rdata,
    input  logic [NBUS-1:0] bus_busy,
    output logic            seq_req,
    output logic [2:0]      seq_op,
    output logic [3:0]      seq_bus,
    output logic [7:0]      seq_wbyte,
    output logic            seq_ack_bit,
    input  logic            seq_done,
    input  logic            seq_nak,
    input  logic            seq_arb_lost,
    input  logic [7:0]      seq_rbyte
);
    logic       enable, cmd_wr, busy, rd_load, sel_busy, captured;
    logic       timer_load, timer_zero;
    logic [7:0] data_q, mon;
    logic [3:0] bus_sel, rsp, cmd_last;

    assign seq_bus = bus_sel;

    mbus_host_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy(busy), .rd_load(rd_load), .rd_byte(seq_rbyte),
        .bus_sel(bus_sel), .sel_busy(sel_busy), .captured(captured), .rsp(rsp),
        .cmd_last(cmd_last), .mon(mon), .enable(enable), .data_q(data_q), .cmd_wr(cmd_wr)
    );

    mbus_byte_fsm #(.NBUS(NBUS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_wr(cmd_wr),
        .cmd_code(host_wdata[3:0]), .data_q(data_q), .bus_busy(bus_busy),
        .timer_zero(timer_zero), .seq_done(seq_done), .seq_nak(seq_nak),
        .seq_arb_lost(seq_arb_lost), .seq_req(seq_req), .seq_op(seq_op),
        .seq_wbyte(seq_wbyte), .seq_ack_bit(seq_ack_bit), .bus_sel(bus_sel),
        .sel_busy(sel_busy), .captured(captured), .busy(busy), .rsp(rsp),
        .cmd_last(cmd_last), .mon(mon), .timer_load(timer_load), .rd_load(rd_load)
    );

    mbus_wait_timer #(.TICK_CYC(TICK_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .count_in(data_q), .zero(timer_zero)
    );

endmodule

// File: tb/mbus_cmd_proc_tb.sv
module mbus_cmd_proc_tb;
    localparam int NBUS = 16;
    localparam int TICK = 4;
    localparam int LAT  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic [NBUS-1:0] bus_busy = '0;
    logic seq_req, seq_ack_bit;
    logic [2:0] seq_op;
    logic [3:0] seq_bus;
    logic [7:0] seq_wbyte;
    logic seq_done = 1'b0, seq_nak = 1'b0, seq_arb_lost = 1'b0;
    logic [7:0] seq_rbyte = 8'd0;

    int checks = 0, failures = 0;
    int nreq = 0, last_op = 0, last_b = 0, last_ack = 0, last_bus = 0;
    logic m_nak = 1'b0, m_arb = 1'b0;
    logic [7:0] m_rb = 8'd0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    mbus_cmd_proc #(.NBUS(NBUS), .TICK_CYC(TICK)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .bus_busy(bus_busy),
        .seq_req(seq_req), .seq_op(seq_op), .seq_bus(seq_bus), .seq_wbyte(seq_wbyte),
        .seq_ack_bit(seq_ack_bit), .seq_done(seq_done), .seq_nak(seq_nak),
        .seq_arb_lost(seq_arb_lost), .seq_rbyte(seq_rbyte)
    );

    // Bit-sequencer model: answer each request after LAT falling edges
    always @(negedge clk) begin
        if (seq_req) begin
            nreq++;
            last_op = seq_op; last_b = seq_wbyte; last_ack = seq_ack_bit; last_bus = seq_bus;
            repeat (LAT - 1) @(negedge clk);
            seq_done = 1'b1; seq_nak = m_nak; seq_arb_lost = m_arb; seq_rbyte = m_rb;
            @(negedge clk);
            seq_done = 1'b0; seq_nak = 1'b0; seq_arb_lost = 1'b0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic wait_cmpl(output int n);
        int v;
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd2, v);
            if (v[7]) break;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic cmd(input logic [7:0] code, output int r);
        int n;
        wr(2'd2, code);
        wait_cmpl(n);
        rd(2'd2, r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v, r, n, req0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(2'd0, v); check("R1 csr", v, 8'h00);
        rd(2'd1, v); check("R1 data", v, 8'h00);
        rd(2'd2, v); check("R1 cmd", v, 8'h80);
        rd(2'd3, v); check("R1 mon", v, 8'h00);

        // R3 command while disabled
        wr(2'd2, 8'h04); rd(2'd2, v); check("R3 disabled start", v, 8'h94);
        check("R3 no request", nreq, 0);

        // R2 control bits and live busy
        wr(2'd0, 8'hC0); rd(2'd0, v); check("R2 csr enable", v, 8'hC0);
        bus_busy[0] = 1'b1; #1; rd(2'd0, v); check("R2 busy bit", v, 8'hE0);
        bus_busy[0] = 1'b0;

        // R4 Set-Bus sweep over all 8-bit values below 32
        begin
            int sel = 0;
            for (int d = 0; d < 32; d++) begin
                wr(2'd1, 8'(d));
                cmd(8'h06, r);
                check("R4 setbus rsp", r, (d < NBUS) ? 8'h86 : 8'h96);
                if (d < NBUS) sel = d;
                rd(2'd0, v); check("R4 setbus sel", v & 8'h0F, sel);
            end
        end

        // R8 write without the bus; R11 stop without the bus
        cmd(8'h01, r); check("R8 write not held", r, 8'h91);
        req0 = nreq;
        cmd(8'h05, r); check("R11 stop not held", r, 8'h85);
        check("R11 no request", nreq, req0);

        // R5 undefined codes
        for (int c = 7; c < 16; c++) begin
            cmd(8'(c), r); check("R5 undefined code", r, 8'h90 | c);
        end

        // R6 start on a busy bus waits, then starts
        wr(2'd1, 8'd3); cmd(8'h06, r);
        bus_busy[3] = 1'b1;
        req0 = nreq;
        wr(2'd2, 8'h04);
        repeat (5) @(negedge clk);
        rd(2'd3, v); check("R14 pending state", v, 8'h20);
        check("R6 no request while busy", nreq, req0);
        rd(2'd2, v); check("R5 complete cleared", v & 8'h80, 0);
        bus_busy[3] = 1'b0;
        wait_cmpl(n); rd(2'd2, r);
        check("R6 start rsp", r, 8'h84);
        check("R6 start op", last_op, 1);
        check("R6 start bus", last_bus, 3);
        rd(2'd0, v); check("R2 captured", v, 8'hD3);
        rd(2'd3, v); check("R14 held state", v, 8'h10);

        // R8 write sweep with and without NAK; R13 ignore while busy
        for (int k = 0; k < 8; k++) begin
            logic [7:0] b = 8'(k * 37 + 5);
            m_nak = k[0];
            wr(2'd1, b);
            wr(2'd2, 8'h01);
            rd(2'd3, v); check("R14 write state", v, 8'h53);
            wr(2'd1, 8'hEE);
            wr(2'd2, 8'h00);
            wait_cmpl(n); rd(2'd2, r);
            check("R8 write rsp", r, k[0] ? 8'hC1 : 8'h81);
            check("R8 write op", last_op, 3);
            check("R8 write byte", last_b, b);
            rd(2'd1, v); check("R13 data kept", v, b);
        end
        m_nak = 1'b0;
        rd(2'd0, v); check("R8 still held", v & 8'h10, 8'h10);

        // R7 repeated start
        cmd(8'h04, r); check("R7 rstart rsp", r, 8'h84);
        check("R7 rstart op", last_op, 2);

        // R9 read sweep
        for (int k = 0; k < 8; k++) begin
            m_rb = 8'(8'hA5 ^ (k * 29));
            cmd(k[0] ? 8'h03 : 8'h02, r);
            check("R9 read rsp", r, k[0] ? 8'h83 : 8'h82);
            check("R9 read op", last_op, 4);
            check("R9 ack bit", last_ack, k[0] ? 0 : 1);
            rd(2'd1, v); check("R9 read byte", v, m_rb);
        end

        // R12 wait timing sweep
        for (int d = 0; d < 7; d++) begin
            wr(2'd1, 8'(d));
            wr(2'd2, 8'h00);
            if (d == 3) begin
                rd(2'd3, v); check("R14 wait state", v, 8'h70);
            end
            wait_cmpl(n);
            check("R12 wait cycles", n, d * TICK + 1);
        end

        // R10 arbitration lost on a write
        m_arb = 1'b1;
        cmd(8'h01, r); check("R10 arb rsp", r, 8'hA1);
        m_arb = 1'b0;
        rd(2'd0, v); check("R10 captured cleared", v & 8'h10, 0);

        // R11 stop after a fresh start
        cmd(8'h04, r); check("R6 fresh start op", last_op, 1);
        cmd(8'h05, r); check("R11 stop rsp", r, 8'h85);
        check("R11 stop op", last_op, 5);
        rd(2'd0, v); check("R11 released", v & 8'h10, 0);

        // R3 disable drops the held bus
        cmd(8'h04, r);
        wr(2'd0, 8'h00);
        @(negedge clk);
        rd(2'd0, v); check("R3 disable drops", v, 8'h03);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule